// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block is a real-time clock core. It keeps seconds, minutes, hours, day of month, month, two-digit year and weekday, each as one packed-BCD byte. The clock advances by one second on each cycle in which the one-second strobe is high and the run bit is set. Software reaches the block through a byte-wide register port. A write is taken on the clock edge. A read is combinational from the addressed register.

A six-field alarm comparator checks the freshly advanced time on every advancing tick. Sticky status flags record second, minute, hour and day rollovers, an alarm match and a power-on event. Software clears each flag by writing a one to its bit. One level interrupt merges the alarm flag with one periodic flag chosen by a period-select field. Each source has its own enable.

Reads of the time offsets return a latched image of the counters. Software refreshes that image by writing the snapshot bit of the control register, so a multi-byte read always sees a single instant. To load a new time, software clears the run bit, writes the time fields, and then sets the run bit again. The two compensation bytes are plain read/write storage. Control bits other than run and snapshot are also plain storage.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, the time reads 00:00:00 on day 01, month 01, year 00, weekday 00. Control (0x0D) reads 0x00, interrupt enables (0x0F) read 0x00, compensation bytes (0x10, 0x11) read 0x00, and status (0x0E) reads 0x80. Status bit 7 is the power-up flag.
- R2: Time advances only on a clock edge where the tick strobe and control bit 0 (run) are both 1. Status bit 1 reads the run bit.
- R3: Seconds and minutes count 00 to 59 in BCD, and hours count 00 to 23. Each carries into the next field when it wraps.
- R4: Day of month wraps to 01 after 31, 30, 28 or 29 according to the month. February has 29 days when the year value is divisible by 4. Month wraps 12 to 01 and carries into the year, and the year wraps 99 to 00.
- R5: Weekday (offset 0x06) counts 00 to 06 and wraps, advancing with every day rollover.
- R6: Writing 1 to control bit 6 copies all seven time counters into the read image at that edge. Offsets 0x00 to 0x06 return the image, not the live counters. Control bit 6 always reads 0.
- R7: On every advancing tick, status bit 2 sets. Bits 3, 4 and 5 set when the minute, hour or day field rolls over on that tick.
- R8: Alarm registers sit at offsets 0x07 to 0x0C, in the order seconds, minutes, hours, day, month, year. Status bit 6 sets when all six fields equal the newly advanced time on an advancing tick.
- R9: Writing status with a 1 in a flag bit clears that flag, and a 0 leaves it unchanged. A flag being set on the same edge as a clear stays set.
- R10: The interrupt output is high when (status bit 6 and enable bit 3) or (the selected periodic flag and enable bit 2). Enable bits 1:0 select the periodic flag: 0 selects status bit 2, 1 bit 3, 2 bit 4 and 3 bit 5.
- R11: With the alarm enabled, the interrupt stays high from the alarm match until software clears status bit 6, whatever ticks occur in between.
- R12: The compensation bytes, the alarm registers and control bits 1 to 5 and 7 read back as written and do not change counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle strobe that marks one elapsed second |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
Every write and every advancing tick takes effect on the clock edge that samples it. A read is valid in the same cycle its address is driven, and the interrupt changes right after the edge that sets or clears a flag. The bench drives each stimulus on a falling edge, so the design samples it at the following rising edge. It then samples `rdata` and `irq` one time unit after the next falling edge, a full cycle after the change. Expected times come from a binary calendar model in the bench that is stepped once per applied tick and converted to BCD only for comparison.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NFIELD    = 7;
    localparam int NALARM    = 6;
    localparam int F_SEC     = 0;
    localparam int F_MIN     = 1;
    localparam int F_HR      = 2;
    localparam int F_DAY     = 3;
    localparam int F_MON     = 4;
    localparam int F_YR      = 5;
    localparam int F_WDAY    = 6;
    localparam int OFS_ALARM = 7;
    localparam int OFS_CTRL  = 13;
    localparam int OFS_STAT  = 14;
    localparam int OFS_INTEN = 15;
    localparam int OFS_COMP0 = 16;
    localparam int OFS_COMP1 = 17;

    typedef logic [7:0] bcd_t;
    typedef bcd_t [NFIELD-1:0] cal_t;
    typedef bcd_t [NALARM-1:0] alm_t;

    function automatic bcd_t bcd_inc(bcd_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd2bin(bcd_t v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    function automatic bcd_t month_len(bcd_t mon, bcd_t yr);
        logic [6:0] m;
        logic [6:0] y;
        m = bcd2bin(mon);
        y = bcd2bin(yr);
        if (m == 7'd2) return (y[1:0] == 2'd0) ? 8'h29 : 8'h28;
        if (m == 7'd4 || m == 7'd6 || m == 7'd9 || m == 7'd11) return 8'h30;
        return 8'h31;
    endfunction
endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt,
    output logic roll_min,
    output logic roll_hr,
    output logic roll_day
);
    always_comb begin
        nxt      = cur;
        roll_min = 1'b0;
        roll_hr  = 1'b0;
        roll_day = 1'b0;
        if (cur[F_SEC] >= 8'h59) begin
            nxt[F_SEC] = 8'h00;
            roll_min   = 1'b1;
            if (cur[F_MIN] >= 8'h59) begin
                nxt[F_MIN] = 8'h00;
                roll_hr    = 1'b1;
                if (cur[F_HR] >= 8'h23) begin
                    nxt[F_HR]   = 8'h00;
                    roll_day    = 1'b1;
                    nxt[F_WDAY] = (cur[F_WDAY] >= 8'h06) ? 8'h00 : cur[F_WDAY] + 8'h01;
                    if (cur[F_DAY] >= month_len(cur[F_MON], cur[F_YR])) begin
                        nxt[F_DAY] = 8'h01;
                        if (cur[F_MON] >= 8'h12) begin
                            nxt[F_MON] = 8'h01;
                            nxt[F_YR]  = (cur[F_YR] >= 8'h99) ? 8'h00 : bcd_inc(cur[F_YR]);
                        end else begin
                            nxt[F_MON] = bcd_inc(cur[F_MON]);
                        end
                    end else begin
                        nxt[F_DAY] = bcd_inc(cur[F_DAY]);
                    end
                end else begin
                    nxt[F_HR] = bcd_inc(cur[F_HR]);
                end
            end else begin
                nxt[F_MIN] = bcd_inc(cur[F_MIN]);
            end
        end else begin
            nxt[F_SEC] = bcd_inc(cur[F_SEC]);
        end
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_pkg::*;
#(
    parameter int FIELDS = NALARM
) (
    input  cal_t tm,
    input  alm_t alm,
    output logic hit
);
    logic [FIELDS-1:0] eq;

    for (genvar i = 0; i < FIELDS; i++) begin : g_eq
        assign eq[i] = (tm[i] == alm[i]);
    end

    assign hit = &eq;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq
);
    localparam cal_t CAL_RST = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    localparam logic [ADDR_W-1:0] A_ALM_LO = ADDR_W'(OFS_ALARM);
    localparam logic [ADDR_W-1:0] A_ALM_HI = ADDR_W'(OFS_ALARM + NALARM);

    typedef struct packed {
        cal_t            tm;
        cal_t            snap;
        alm_t            alm;
        logic [7:0]      ctrl;
        logic [7:2]      flags;
        logic [3:0]      inten;
        logic [1:0][7:0] comp;
    } state_t;

    state_t            s_d, s_q;
    cal_t              tm_nxt;
    logic              r_min, r_hr, r_day, alm_hit, advance, sel_flag;
    logic [7:2]        fl_set, fl_clr;
    logic [ADDR_W-1:0] aoff;
    logic              is_time, is_alm;

    logic              run_q;
    cal_t              tm_q;
    logic [7:2]        flags_q;
    logic [3:0]        inten_q;

    assign run_q   = s_q.ctrl[0];
    assign tm_q    = s_q.tm;
    assign flags_q = s_q.flags;
    assign inten_q = s_q.inten;

    rtc_cal_step u_step (
        .cur      (s_q.tm),
        .nxt      (tm_nxt),
        .roll_min (r_min),
        .roll_hr  (r_hr),
        .roll_day (r_day)
    );

    rtc_alarm_cmp #(.FIELDS(NALARM)) u_alm (
        .tm  (tm_nxt),
        .alm (s_q.alm),
        .hit (alm_hit)
    );

    assign advance = tick_1s & run_q;
    assign aoff    = addr - A_ALM_LO;
    assign is_time = (addr < ADDR_W'(NFIELD));
    assign is_alm  = (addr >= A_ALM_LO) && (addr < A_ALM_HI);

    always_comb begin
        s_d    = s_q;
        fl_set = '0;
        fl_clr = '0;
        if (advance) begin
            s_d.tm = tm_nxt;
            fl_set = {1'b0, alm_hit, r_day, r_hr, r_min, 1'b1};
        end
        if (wr_en) begin
            if (is_time) begin
                s_d.tm[addr[2:0]] = wdata;
            end else if (is_alm) begin
                s_d.alm[aoff[2:0]] = wdata;
            end else if (addr == ADDR_W'(OFS_CTRL)) begin
                s_d.ctrl = wdata & 8'hBF;
                if (wdata[6]) s_d.snap = s_q.tm;
            end else if (addr == ADDR_W'(OFS_STAT)) begin
                fl_clr = wdata[7:2];
            end else if (addr == ADDR_W'(OFS_INTEN)) begin
                s_d.inten = wdata[3:0];
            end else if (addr == ADDR_W'(OFS_COMP0)) begin
                s_d.comp[0] = wdata;
            end else if (addr == ADDR_W'(OFS_COMP1)) begin
                s_d.comp[1] = wdata;
            end
        end
        s_d.flags = (s_q.flags & ~fl_clr) | fl_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.tm    <= CAL_RST;
            s_q.snap  <= CAL_RST;
            s_q.alm   <= '0;
            s_q.ctrl  <= '0;
            s_q.flags <= 6'b100000;
            s_q.inten <= '0;
            s_q.comp  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (is_time) begin
            rdata = s_q.snap[addr[2:0]];
        end else if (is_alm) begin
            rdata = s_q.alm[aoff[2:0]];
        end else if (addr == ADDR_W'(OFS_CTRL)) begin
            rdata = s_q.ctrl;
        end else if (addr == ADDR_W'(OFS_STAT)) begin
            rdata = {s_q.flags, run_q, 1'b0};
        end else if (addr == ADDR_W'(OFS_INTEN)) begin
            rdata = {4'h0, s_q.inten};
        end else if (addr == ADDR_W'(OFS_COMP0)) begin
            rdata = s_q.comp[0];
        end else if (addr == ADDR_W'(OFS_COMP1)) begin
            rdata = s_q.comp[1];
        end
    end

    always_comb begin
        case (s_q.inten[1:0])
            2'd0:    sel_flag = s_q.flags[2];
            2'd1:    sel_flag = s_q.flags[3];
            2'd2:    sel_flag = s_q.flags[4];
            default: sel_flag = s_q.flags[5];
        endcase
    end

    assign irq = (s_q.flags[6] & s_q.inten[3]) | (sel_flag & s_q.inten[2]);
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1s,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wd_alm_clr,
    input logic              irq,
    input logic              run,
    input cal_t              tm,
    input logic              fl_pwr,
    input logic              fl_alm,
    input logic              fl_sec,
    input logic              alm_en
);
    logic time_wr;
    logic alm_clr_wr;
    assign time_wr    = wr_en && (addr < ADDR_W'(NFIELD));
    assign alm_clr_wr = wr_en && (addr == ADDR_W'(OFS_STAT)) && wd_alm_clr;

    assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !time_wr) |=> $stable(tm));

    assert_sec_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_1s && !wr_en) |=> (tm[F_SEC] != $past(tm[F_SEC])));

    assert_sec_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_1s) |=> fl_sec);

    assert_alarm_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_alm && !alm_clr_wr) |=> fl_alm);

    assert_irq_alarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_alm && alm_en) |-> irq);

    assert_no_pwr_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(fl_pwr));
endmodule

bind bcd_rtc_core rtc_core_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1s    (tick_1s),
    .wr_en      (wr_en),
    .addr       (addr),
    .wd_alm_clr (wdata[6]),
    .irq        (irq),
    .run        (run_q),
    .tm         (tm_q),
    .fl_pwr     (flags_q[7]),
    .fl_alm     (flags_q[6]),
    .fl_sec     (flags_q[2]),
    .alm_en     (inten_q[3])
);

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int vectors = 0;
    int errors  = 0;
    int ms, mm, mh, md, mmo, my, mw;
    logic [7:0] ev_acc;

    bcd_rtc_core #(.ADDR_W(5)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        ev_acc[2] = 1'b1;
        ms++;
        if (ms == 60) begin
            ms = 0; ev_acc[3] = 1'b1; mm++;
            if (mm == 60) begin
                mm = 0; ev_acc[4] = 1'b1; mh++;
                if (mh == 24) begin
                    mh = 0; ev_acc[5] = 1'b1; mw = (mw + 1) % 7; md++;
                    if (md > dim(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic check(string req, int got, int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(int a, int exp, string req);
        addr = 5'(a);
        #1;
        check(req, int'(rdata), exp);
    endtask

    task automatic tk();
        @(negedge clk);
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
        model_step();
    endtask

    task automatic irq_chk(int exp, string req);
        #1;
        check(req, int'(irq), exp);
    endtask

    task automatic set_model(int h, int m, int s, int d, int mo, int y, int w);
        mh = h; mm = m; ms = s; md = d; mmo = mo; my = y; mw = w;
    endtask

    task automatic load_and_run(int ctrl_after);
        wr(13, 8'h00);
        wr(0, to_bcd(ms)); wr(1, to_bcd(mm)); wr(2, to_bcd(mh));
        wr(3, to_bcd(md)); wr(4, to_bcd(mmo)); wr(5, to_bcd(my)); wr(6, to_bcd(mw));
        wr(13, ctrl_after);
        ev_acc = '0;
    endtask

    task automatic snap_chk(int ctrl_keep, string req);
        wr(13, ctrl_keep | 8'h40);
        rd_chk(0, to_bcd(ms), req); rd_chk(1, to_bcd(mm), req);
        rd_chk(2, to_bcd(mh), req); rd_chk(3, to_bcd(md), req);
        rd_chk(4, to_bcd(mmo), req); rd_chk(5, to_bcd(my), req);
        rd_chk(6, to_bcd(mw), req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        ev_acc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        set_model(0, 0, 0, 1, 1, 0, 0);
        rd_chk(0, 8'h00, "R1"); rd_chk(3, 8'h01, "R1"); rd_chk(4, 8'h01, "R1");
        rd_chk(6, 8'h00, "R1"); rd_chk(13, 8'h00, "R1"); rd_chk(14, 8'h80, "R1");
        rd_chk(15, 8'h00, "R1"); rd_chk(16, 8'h00, "R1"); rd_chk(17, 8'h00, "R1");
        irq_chk(0, "R1");

        // R2 stopped clock ignores ticks
        @(negedge clk); tick_1s = 1'b1;
        repeat (3) @(negedge clk);
        tick_1s = 1'b0;
        snap_chk(8'h00, "R2");
        rd_chk(14, 8'h80, "R2");

        // R9 write-one-to-clear
        wr(14, 8'h00); rd_chk(14, 8'h80, "R9");
        wr(14, 8'h80); rd_chk(14, 8'h00, "R9");

        // R2 run bit reported
        wr(13, 8'h01); rd_chk(14, 8'h02, "R2");

        // random loads and runs: R3 R4 R5 R7
        for (int it = 0; it < 200; it++) begin
            int n;
            mmo = 1 + int'($urandom % 12);
            my  = int'($urandom % 100);
            md  = ($urandom % 2 == 0) ? dim(mmo, my) : 1 + int'($urandom % dim(mmo, my));
            mh  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
            mm  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            ms  = ($urandom % 3 != 0) ? 57 + int'($urandom % 3) : int'($urandom % 60);
            mw  = int'($urandom % 7);
            load_and_run(8'h01);
            wr(14, 8'hFC);
            ev_acc = '0;
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) tk();
            snap_chk(8'h01, "R3_R4_R5");
            rd_chk(14, int'(ev_acc) | 8'h02, "R7");
        end

        // R3 R4 R5 R7 year wrap
        set_model(23, 59, 59, 31, 12, 99, 6);
        load_and_run(8'h01); wr(14, 8'hFC);
        tk();
        snap_chk(8'h01, "R4");
        rd_chk(0, 8'h00, "R3"); rd_chk(5, 8'h00, "R4"); rd_chk(6, 8'h00, "R5");
        rd_chk(14, 8'h3E, "R7");

        // R4 leap and non-leap February, 30-day month
        set_model(23, 59, 59, 28, 2, 24, 1);
        load_and_run(8'h01); tk(); snap_chk(8'h01, "R4");
        rd_chk(3, 8'h29, "R4");
        set_model(23, 59, 59, 28, 2, 23, 1);
        load_and_run(8'h01); tk(); snap_chk(8'h01, "R4");
        rd_chk(4, 8'h03, "R4");
        set_model(23, 59, 59, 30, 4, 10, 1);
        load_and_run(8'h01); tk(); snap_chk(8'h01, "R4");
        rd_chk(4, 8'h05, "R4");

        // R6 snapshot coherence
        set_model(5, 6, 7, 9, 9, 9, 2);
        load_and_run(8'h01);
        wr(13, 8'h41);
        tk(); tk();
        rd_chk(0, 8'h07, "R6"); rd_chk(13, 8'h01, "R6");
        snap_chk(8'h01, "R6");
        rd_chk(0, 8'h09, "R6");

        // R12 storage only
        wr(16, 8'hA5); wr(17, 8'h5A);
        rd_chk(16, 8'hA5, "R12"); rd_chk(17, 8'h5A, "R12");
        set_model(1, 2, 3, 4, 5, 6, 3);
        load_and_run(8'hBF);
        rd_chk(13, 8'hBF, "R12");
        tk();
        snap_chk(8'hBF, "R12");
        rd_chk(13, 8'hBF, "R12");

        // R8 R10 R11 alarm
        set_model(12, 34, 56, 15, 6, 24, 3);
        load_and_run(8'h01);
        wr(7, 8'h57); wr(8, 8'h34); wr(9, 8'h12); wr(10, 8'h15); wr(11, 8'h06); wr(12, 8'h24);
        rd_chk(7, 8'h57, "R12"); rd_chk(12, 8'h24, "R12");
        wr(14, 8'hFC); wr(15, 8'h08);
        irq_chk(0, "R10");
        tk();
        irq_chk(1, "R10");
        rd_chk(14, 8'h46, "R8");
        tk();
        irq_chk(1, "R11");
        wr(14, 8'h3C);
        irq_chk(1, "R11");
        rd_chk(14, 8'h42, "R9");
        wr(14, 8'h40);
        irq_chk(0, "R11");
        rd_chk(14, 8'h02, "R8");
        wr(12, 8'h25);

        // R10 periodic select
        wr(15, 8'h05);
        set_model(10, 0, 58, 1, 1, 1, 0);
        load_and_run(8'h01); wr(14, 8'hFC);
        tk(); irq_chk(0, "R10");
        tk(); irq_chk(1, "R10");
        wr(15, 8'h04); irq_chk(1, "R10");
        wr(14, 8'hFC); irq_chk(0, "R10");
        wr(15, 8'h07);
        set_model(23, 59, 58, 1, 1, 1, 0);
        load_and_run(8'h01); wr(14, 8'hFC);
        tk(); irq_chk(0, "R10");
        tk(); irq_chk(1, "R10");
        wr(15, 8'h06); irq_chk(1, "R10");
        wr(15, 8'h00); irq_chk(0, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule